// File: doc/BRIEF.md
# UART Control, Status and Interrupt Register Unit

This block is the register side of a serial port. A 32-bit register bus sees three registers: a control word at byte offset 0x08, a status word at 0x0C and a clock register at 0x10 whose low ten bits hold the baud divisor. The register window is 0x14 bytes wide. The control word drives the FIFO clears, loopback, break, parity and stop-bit settings straight out to the transmitter and receiver, which are separate blocks. The block returns their level flags and error pulses to software through the status word.

Four error conditions are held in sticky bits, and a read of the status word clears them. Level flags pass through as they are. One interrupt line is formed from nine sources, and each source has its own enable bit. A soft reset is requested through the control word. It puts every register back to its default and pulses a reset to the datapath for exactly one cycle.

Top module: `serial_csr`

## Requirements
- R1: After reset the control word reads 0, the clock register reads DIV_RST (14), the sticky error bits are 0 and `irq` is 0.
- R2: A write to 0x08 with bit 31 clear stores bits 30:0, and a read returns them. The stored bits drive these outputs: bit 15 `tx_fifo_clr`, bit 14 `rx_fifo_clr`, bit 13 `mirror_en`, bit 12 `loop_en`, bit 11 `break_tx`, bit 10 `parity_en`, bit 9 `two_stop`.
- R3: A write to 0x10 stores all 32 bits, a read returns them, and bits 9:0 drive `baud_div`.
- R4: A read of 0x0C returns `st_live[k]` in bit k+4 for k = 0..9, with nothing registered in between. Bits 31:14 read 0.
- R5: A pulse on `err_pulse[k]` sets status bit k (0 overrun, 1 parity, 2 frame, 3 break). The bit stays set until it is cleared.
- R6: A read of 0x0C clears the sticky bits after it returns them. An error pulse in the same cycle as that read leaves its bit set.
- R7: `irq` is the OR over nine pairs of control bit and status bit: 8 with 10, 7 with 7, 6 with 6, 5 with 5, 4 with 4, and 3..0 with 3..0.
- R8: A control write with bit 31 set stores nothing else. It raises `core_rst`, `tx_fifo_clr` and `rx_fifo_clr` for exactly one cycle, and then every register is back at its R1 value.
- R9: A write to any offset other than 0x08, 0x0C or 0x10 changes nothing, and a read of such an offset returns 0.
- R10: A write to 0x0C leaves the sticky bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| st_live | input | 10 | Live level flags from the datapath |
| err_pulse | input | 4 | Error event pulses from the receiver |
| tx_fifo_clr | output | 1 | Clear the transmit FIFO |
| rx_fifo_clr | output | 1 | Clear the receive FIFO |
| mirror_en | output | 1 | Status mirror enable |
| loop_en | output | 1 | Loopback enable |
| break_tx | output | 1 | Send a break |
| parity_en | output | 1 | Parity enable |
| two_stop | output | 1 | Two stop bits |
| baud_div | output | DIV_W (10) | Baud divisor |
| core_rst | output | 1 | One-cycle soft reset to the datapath |
| irq | output | 1 | Combined interrupt |

## Verification
The clear-on-read of the status word can land in the same cycle as a new error pulse. The bench provokes this by raising `err_pulse` while a status read is on the bus. In that cycle the read must still return the old sticky value. A second status read must then show the new bit, and the bench checks both. The randomized sequence mixes error pulses, enable writes and level changes, so `irq` is also checked in cycles where a source and its enable change together.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned N_LIVE  = 10;
   localparam int unsigned N_ERR   = 4;
   localparam int unsigned N_IRQ   = 9;
   localparam int unsigned STAT_W  = N_LIVE + N_ERR;

   localparam int unsigned OFS_CTRL = 32'h08;
   localparam int unsigned OFS_STAT = 32'h0C;
   localparam int unsigned OFS_CLK  = 32'h10;

   localparam int unsigned C_SRST  = 31;
   localparam int unsigned C_TXCLR = 15;
   localparam int unsigned C_RXCLR = 14;
   localparam int unsigned C_MIRR  = 13;
   localparam int unsigned C_LOOP  = 12;
   localparam int unsigned C_BRK   = 11;
   localparam int unsigned C_PAR   = 10;
   localparam int unsigned C_STOP2 = 9;

   // interrupt source vector, ordered like the enable bits 8..0
   function automatic logic [N_IRQ-1:0] irq_sources(input logic [STAT_W-1:0] s);
      return {s[10], s[7], s[6], s[5], s[4], s[3:0]};
   endfunction
endpackage

// File: rtl/serial_csr_ctrl.sv
module serial_csr_ctrl #(
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned DIV_RST = 14
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl,
   input  logic        wr_clk,
   input  logic [31:0] wdata,
   output logic [30:0] ctrl_q,
   output logic [31:0] clk_q,
   output logic        srst_q
);
   localparam logic [31:0] CLK_RST = 32'(DIV_RST);

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
      $error("serial_csr_ctrl: DIV_W out of range");
   end
   if (DIV_RST >= (1 << DIV_W)) begin : g_bad_div_rst
      $error("serial_csr_ctrl: DIV_RST does not fit DIV_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         clk_q  <= CLK_RST;
         srst_q <= 1'b0;
      end else if (srst_q) begin
         ctrl_q <= '0;
         clk_q  <= CLK_RST;
         srst_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            if (wdata[31]) srst_q <= 1'b1;
            else           ctrl_q <= wdata[30:0];
         end
         if (wr_clk) clk_q <= wdata;
      end
   end

   AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> !srst_q); // R8
   AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (ctrl_q == '0 && clk_q == CLK_RST)); // R8
   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[31] && !srst_q) |=> ctrl_q == $past(wdata[30:0])); // R2
   AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_clk && !srst_q) |=> clk_q == $past(clk_q)); // R3
endmodule

// File: rtl/serial_csr_stat.sv
module serial_csr_stat #(
   parameter int unsigned N_LIVE      = 10,
   parameter int unsigned N_ERR       = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              rd_clr,
   input  logic [N_ERR-1:0]  err_evt,
   input  logic [N_LIVE-1:0] live_in,
   output logic [N_LIVE-1:0] live_q,
   output logic [N_ERR-1:0]  sticky_q
);
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("serial_csr_stat: SYNC_STAGES above 4");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign live_q = live_in;
   end else begin : g_sync
      logic [N_LIVE-1:0] pipe_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '0;
         end else begin
            pipe_q[0] <= live_in;
            for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         end
      end
      assign live_q = pipe_q[SYNC_STAGES-1];
   end

   // a fresh event outranks the clear of the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sticky_q <= '0;
      else if (srst)   sticky_q <= '0;
      else             sticky_q <= (sticky_q & ~{N_ERR{rd_clr}}) | err_evt;
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !srst) |=> (sticky_q & $past(sticky_q)) == $past(sticky_q)); // R5
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> (sticky_q & $past(err_evt)) == $past(err_evt)); // R6
   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && err_evt == '0) |=> sticky_q == '0); // R6
endmodule

// File: rtl/serial_csr_irq.sv
module serial_csr_irq #(
   parameter int unsigned N_SRC   = 9,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] en_i,
   input  logic [N_SRC-1:0] src_i,
   output logic             irq_o
);
   logic [N_SRC-1:0] hit;
   assign hit = en_i & src_i;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= |hit;
      end
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         (en_i == '0) |=> !irq_o); // R7
   end else begin : g_comb
      assign irq_o = |hit;
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         (en_i == '0) |-> !irq_o); // R7
   end
endmodule

// File: rtl/serial_csr.sv
module serial_csr
   import serial_csr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DIV_W       = 10,
   parameter int unsigned DIV_RST     = 14,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [9:0]        st_live,
   input  logic [3:0]        err_pulse,
   output logic              tx_fifo_clr,
   output logic              rx_fifo_clr,
   output logic              mirror_en,
   output logic              loop_en,
   output logic              break_tx,
   output logic              parity_en,
   output logic              two_stop,
   output logic [DIV_W-1:0]  baud_div,
   output logic              core_rst,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFS_CLK);

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr_w
      $error("serial_csr: ADDR_W must cover a 0x14 byte window");
   end

   logic hit_ctrl, hit_stat, hit_clk, hit_any;
   assign hit_ctrl = (bus_addr == A_CTRL);
   assign hit_stat = (bus_addr == A_STAT);
   assign hit_clk  = (bus_addr == A_CLK);
   assign hit_any  = hit_ctrl | hit_stat | hit_clk;

   logic [30:0]         ctrl_q;
   logic [31:0]         clk_q;
   logic                srst_q;
   logic [N_LIVE-1:0]   live_q;
   logic [N_ERR-1:0]    sticky_q;
   logic [STAT_W-1:0]   stat_w;

   serial_csr_ctrl #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (bus_wr & hit_ctrl),
      .wr_clk  (bus_wr & hit_clk),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .clk_q   (clk_q),
      .srst_q  (srst_q)
   );

   serial_csr_stat #(.N_LIVE(N_LIVE), .N_ERR(N_ERR), .SYNC_STAGES(SYNC_STAGES)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst_q),
      .rd_clr   (bus_rd & hit_stat),
      .err_evt  (err_pulse),
      .live_in  (st_live),
      .live_q   (live_q),
      .sticky_q (sticky_q)
   );

   assign stat_w = {live_q, sticky_q};

   serial_csr_irq #(.N_SRC(N_IRQ), .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (ctrl_q[N_IRQ-1:0]),
      .src_i (irq_sources(stat_w)),
      .irq_o (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            A_CTRL:  bus_rdata = {srst_q, ctrl_q};
            A_STAT:  bus_rdata = {{(REG_W-STAT_W){1'b0}}, stat_w};
            A_CLK:   bus_rdata = clk_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign tx_fifo_clr = ctrl_q[C_TXCLR] | srst_q;
   assign rx_fifo_clr = ctrl_q[C_RXCLR] | srst_q;
   assign mirror_en   = ctrl_q[C_MIRR];
   assign loop_en     = ctrl_q[C_LOOP];
   assign break_tx    = ctrl_q[C_BRK];
   assign parity_en   = ctrl_q[C_PAR];
   assign two_stop    = ctrl_q[C_STOP2];
   assign baud_div    = clk_q[DIV_W-1:0];
   assign core_rst    = srst_q;

   AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit_any) |-> bus_rdata == '0); // R9
   AST_UNDEF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit_any && !srst_q) |=> baud_div == $past(baud_div)); // R9
   AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_stat) |-> bus_rdata[31:STAT_W] == '0); // R4
endmodule

// File: tb/serial_csr_test.sv
module serial_csr_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] DIV_DEF = 32'd14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [9:0]  st_live = '0;
   logic [3:0]  err_pulse = '0;
   logic tx_fifo_clr, rx_fifo_clr, mirror_en, loop_en, break_tx, parity_en, two_stop;
   logic [9:0]  baud_div;
   logic core_rst, irq;

   int n_chk = 0, n_fail = 0;
   logic [30:0] m_ctrl;
   logic [31:0] m_clk;
   logic [3:0]  m_sticky;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_csr uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_live(st_live), .err_pulse(err_pulse),
      .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr), .mirror_en(mirror_en),
      .loop_en(loop_en), .break_tx(break_tx), .parity_en(parity_en), .two_stop(two_stop),
      .baud_div(baud_div), .core_rst(core_rst), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_stat();
      return {18'b0, st_live, m_sticky};
   endfunction

   function automatic logic exp_irq();
      logic [31:0] s;
      logic [8:0]  src;
      s = exp_stat();
      src = {s[10], s[7], s[6], s[5], s[4], s[3], s[2], s[1], s[0]};
      return |(m_ctrl[8:0] & src);
   endfunction

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic read_stat_chk(input string req);
      logic [31:0] d;
      rd(5'h0C, d);
      chk(req, d, exp_stat());
      m_sticky = '0;
   endtask

   task automatic pulse(input logic [3:0] e);
      err_pulse = e;
      @(negedge clk);
      err_pulse = '0;
      m_sticky |= e;
   endtask

   task automatic chk_ctrl_pins();
      chk("R2", {25'b0, tx_fifo_clr, rx_fifo_clr, mirror_en, loop_en, break_tx, parity_en, two_stop},
          {25'b0, m_ctrl[15:9]});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240607));
      m_ctrl = '0; m_clk = DIV_DEF; m_sticky = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h08, d); chk("R1", d, 32'h0);
      rd(5'h10, d); chk("R1", d, DIV_DEF);
      chk("R1", {22'b0, baud_div}, DIV_DEF);
      read_stat_chk("R1");
      chk("R1", {31'b0, irq}, 32'h0);

      // R2 and R3 directed
      wr(5'h08, 32'h0000_FE00); m_ctrl = 31'h0000_FE00;
      chk_ctrl_pins();
      rd(5'h08, d); chk("R2", d, 32'h0000_FE00);
      wr(5'h10, 32'hABCD_E3FF); m_clk = 32'hABCD_E3FF;
      chk("R3", {22'b0, baud_div}, 32'h3FF);
      rd(5'h10, d); chk("R3", d, m_clk);

      // R4 live mapping
      st_live = 10'b10_0000_0001; #1;
      read_stat_chk("R4");

      // R9 undefined offsets
      wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h14, 32'hFFFF_FFFF); wr(5'h09, 32'hFFFF_FFFF);
      rd(5'h08, d); chk("R9", d, {1'b0, m_ctrl});
      rd(5'h10, d); chk("R9", d, m_clk);
      rd(5'h00, d); chk("R9", d, 32'h0);
      rd(5'h14, d); chk("R9", d, 32'h0);
      rd(5'h0D, d); chk("R9", d, 32'h0);

      // R5 sticky, R10 write to status ignored
      pulse(4'b1010);
      wr(5'h0C, 32'hFFFF_FFFF);
      read_stat_chk("R10");
      read_stat_chk("R6");

      // R6 event in the same cycle as the clearing read
      pulse(4'b0001);
      bus_rd = 1'b1; bus_addr = 5'h0C; err_pulse = 4'b0100;
      #1 d = bus_rdata;
      chk("R6", d, exp_stat());
      @(negedge clk);
      bus_rd = 1'b0; err_pulse = '0;
      m_sticky = 4'b0100;
      read_stat_chk("R6");

      // R7 interrupt sources
      st_live = '0;
      wr(5'h08, 32'h0000_0008); m_ctrl = 31'h8;
      chk("R7", {31'b0, irq}, 32'h0);
      pulse(4'b1000);
      chk("R7", {31'b0, irq}, 32'h1);
      read_stat_chk("R7");
      chk("R7", {31'b0, irq}, 32'h0);
      wr(5'h08, 32'h0000_0100); m_ctrl = 31'h100;
      st_live = 10'b00_0100_0000; #1;
      chk("R7", {31'b0, irq}, 32'h1);
      st_live = 10'b11_1011_1111; #1;
      chk("R7", {31'b0, irq}, 32'h0);

      // R8 soft reset
      wr(5'h10, 32'h0000_0123);
      pulse(4'b0110);
      wr(5'h08, 32'h8000_1234);
      chk("R8", {29'b0, core_rst, tx_fifo_clr, rx_fifo_clr}, 32'h7);
      @(negedge clk);
      m_ctrl = '0; m_clk = DIV_DEF; m_sticky = '0;
      chk("R8", {31'b0, core_rst}, 32'h0);
      rd(5'h08, d); chk("R8", d, 32'h0);
      rd(5'h10, d); chk("R8", d, DIV_DEF);
      read_stat_chk("R8");

      // random mix
      for (int it = 0; it < 600; it++) begin
         int unsigned op;
         logic [31:0] r;
         op = $urandom % 8;
         r  = $urandom;
         case (op)
            0: begin wr(5'h08, r & 32'h7FFF_FFFF); m_ctrl = r[30:0]; chk_ctrl_pins(); end
            1: begin wr(5'h10, r); m_clk = r; chk("R3", {22'b0, baud_div}, {22'b0, r[9:0]}); end
            2: begin st_live = r[9:0]; #1 chk("R7", {31'b0, irq}, {31'b0, exp_irq()}); end
            3: begin pulse(r[3:0]); chk("R5", {31'b0, irq}, {31'b0, exp_irq()}); end
            4: read_stat_chk("R5");
            5: begin rd(5'h08, d); chk("R2", d, {1'b0, m_ctrl}); end
            6: begin rd(5'h10, d); chk("R3", d, m_clk); end
            default: begin
               bus_rd = 1'b1; bus_addr = 5'h0C; err_pulse = r[7:4];
               #1 d = bus_rdata;
               chk("R6", d, exp_stat());
               @(negedge clk);
               bus_rd = 1'b0; err_pulse = '0;
               m_sticky = r[7:4];
               chk("R7", {31'b0, irq}, {31'b0, exp_irq()});
            end
         endcase
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule